// File: doc/BRIEF.md
# Dual 12-bit DAC Code Loader

This block sits on an 8-bit host write bus and builds the 12-bit codes for two DACs, one that steers the oscillator control voltage and one that sets receiver gain. Each DAC has its own bus address. A 12-bit code arrives as two byte writes to that address. The first write carries the low 8 bits. The second write carries the top 4 bits. A select bit in a separate mode register tells the block which half a byte write is for. A larger code gives a higher DAC output.

The low byte is held in a staging register. The DAC output register is loaded only by the high-half write, which joins its nibble to the staged byte. A half-finished value therefore never reaches the converter.

The mode register also drives several control outputs: an integrator time-constant select, a gate-source select, an interrupt enable, an enable for counter five, and an enable for the group-interval gate.

Top module: `dac_byte_loader`

## Requirements
- R1: After reset the oscillator code is 2048, the gain code is 1440, and every mode field is 0. The reset values also fill the staging registers, so the staged low bytes are 0x00 (oscillator) and 0xA0 (gain).
- R2: A write to address 7 loads the whole mode byte. Bits [1:0] drive `integ_tc`, bits [3:2] drive `gate_sel`, bit 4 drives `hi_sel`, bit 5 drives `irq_en`, bit 6 drives `cnt5_en` and bit 7 drives `gri_en`.
- R3: A write to address 4 (oscillator) or address 5 (gain) while `hi_sel` is 0 stores the byte as that channel's staged low byte and leaves that channel's code output unchanged.
- R4: A write to address 4 or 5 while `hi_sel` is 1 sets that channel's code to {wdata[3:0], staged low byte}.
- R5: During a high-half write, wdata[7:4] has no effect on the code.
- R6: A write to one DAC address changes neither the code nor the staged byte of the other channel.
- R7: Writes to addresses 0, 1, 2, 3 and 6 change no output.
- R8: When `wr_en` is low, nothing changes, whatever the address and data.
- R9: A high-half write with no new low write before it reuses the last staged low byte. The staged byte is not cleared after it is used.
- R10: A code or mode output changes at the first rising clock edge on which the write is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle |
| addr | input | 3 | Write address |
| wdata | input | 8 | Write data byte |
| vco_code | output | 12 | Oscillator DAC code |
| agc_code | output | 12 | Gain DAC code |
| integ_tc | output | 2 | Integrator time-constant select |
| gate_sel | output | 2 | Gate-source select |
| hi_sel | output | 1 | 1 = DAC writes carry the top nibble |
| irq_en | output | 1 | Interrupt enable |
| cnt5_en | output | 1 | Counter-five enable |
| gri_en | output | 1 | Group-interval gate enable |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are stable around each rising edge. They also assume that each clock cycle carries at most one write, so the previous cycle's inputs alone explain any change in an output. The bench changes inputs only on falling edges and samples outputs one half-cycle later. Its random phase draws every address, data byte and strobe value, so writes to the mode register change `hi_sel` between DAC writes. Directed cases cover a high write with no fresh low byte and a high write with the upper nibble set.

// File: rtl/dac_byte_loader.sv
module dac_byte_loader #(
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 3,
  parameter int VCO_ADDR  = 4,
  parameter int AGC_ADDR  = 5,
  parameter int MODE_ADDR = 7,
  parameter int VCO_RST   = 2048,
  parameter int AGC_RST   = 1440
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] vco_code,
  output logic [CODE_W-1:0] agc_code,
  output logic [1:0]        integ_tc,
  output logic [1:0]        gate_sel,
  output logic              hi_sel,
  output logic              irq_en,
  output logic              cnt5_en,
  output logic              gri_en
);
  localparam int HI_W = CODE_W - DATA_W;
  localparam logic [CODE_W-1:0] VCO_INIT = CODE_W'(VCO_RST);
  localparam logic [CODE_W-1:0] AGC_INIT = CODE_W'(AGC_RST);

  logic [7:0]        mode_q;
  logic [DATA_W-1:0] vco_lo, agc_lo;

  wire wr_vco  = wr_en && (addr == ADDR_W'(VCO_ADDR));
  wire wr_agc  = wr_en && (addr == ADDR_W'(AGC_ADDR));
  wire wr_mode = wr_en && (addr == ADDR_W'(MODE_ADDR));
  wire hi_q    = mode_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_mode) mode_q <= wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vco_lo   <= VCO_INIT[DATA_W-1:0];
      vco_code <= VCO_INIT;
    end else if (wr_vco) begin
      if (hi_q) vco_code <= {wdata[HI_W-1:0], vco_lo};
      else      vco_lo   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agc_lo   <= AGC_INIT[DATA_W-1:0];
      agc_code <= AGC_INIT;
    end else if (wr_agc) begin
      if (hi_q) agc_code <= {wdata[HI_W-1:0], agc_lo};
      else      agc_lo   <= wdata;
    end
  end

  assign integ_tc = mode_q[1:0];
  assign gate_sel = mode_q[3:2];
  assign hi_sel   = hi_q;
  assign irq_en   = mode_q[5];
  assign cnt5_en  = mode_q[6];
  assign gri_en   = mode_q[7];
endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk #(
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 3,
  parameter int VCO_ADDR  = 4,
  parameter int AGC_ADDR  = 5,
  parameter int MODE_ADDR = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [CODE_W-1:0] vco_code,
  input logic [CODE_W-1:0] agc_code,
  input logic [1:0]        integ_tc,
  input logic [1:0]        gate_sel,
  input logic              hi_sel,
  input logic              irq_en,
  input logic              cnt5_en,
  input logic              gri_en
);
  localparam int HI_W = CODE_W - DATA_W;
  wire [7:0] mode_b = {gri_en, cnt5_en, irq_en, hi_sel, gate_sel, integ_tc};
  wire v_hit = wr_en && addr == ADDR_W'(VCO_ADDR);
  wire a_hit = wr_en && addr == ADDR_W'(AGC_ADDR);
  wire m_hit = wr_en && addr == ADDR_W'(MODE_ADDR);

  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(m_hit) |-> mode_b == $past(wdata[7:0]));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(m_hit) |-> $stable(mode_b));
  p_vco_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(v_hit && hi_sel) |-> vco_code[CODE_W-1:DATA_W] == $past(wdata[HI_W-1:0]));
  p_agc_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(a_hit && hi_sel) |-> agc_code[CODE_W-1:DATA_W] == $past(wdata[HI_W-1:0]));
  p_vco_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(v_hit && hi_sel) |-> $stable(vco_code));
  p_agc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(a_hit && hi_sel) |-> $stable(agc_code));
endmodule

bind dac_byte_loader dac_byte_loader_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
  .VCO_ADDR(VCO_ADDR), .AGC_ADDR(AGC_ADDR), .MODE_ADDR(MODE_ADDR)
) u_chk (.*);

// File: tb/dac_byte_loader_bench.sv
module dac_byte_loader_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [11:0] vco_code, agc_code;
  logic [1:0] integ_tc, gate_sel;
  logic hi_sel, irq_en, cnt5_en, gri_en;

  int n_vec = 0, n_bad = 0;
  logic [7:0]  m_mode, m_vlo, m_alo;
  logic [11:0] m_vco, m_agc;

  always #5 clk = ~clk;

  dac_byte_loader u_dac_byte_loader (.*);

  function automatic logic [11:0] join_code(input logic [7:0] d, input logic [7:0] lo);
    return {d[3:0], lo};
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " vco"}, vco_code, m_vco);
    chk({tag, " agc"}, agc_code, m_agc);
    chk({tag, " mode"}, {4'd0, gri_en, cnt5_en, irq_en, hi_sel, gate_sel, integ_tc}, {4'd0, m_mode});
  endtask

  task automatic model(input logic we, input logic [2:0] a, input logic [7:0] d);
    if (!we) return;
    case (a)
      3'd7: m_mode = d;
      3'd4: if (m_mode[4]) m_vco = join_code(d, m_vlo); else m_vlo = d;
      3'd5: if (m_mode[4]) m_agc = join_code(d, m_alo); else m_alo = d;
      default: ;
    endcase
  endtask

  task automatic drive(input logic we, input logic [2:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #1 chk({"R10 pre-edge ", tag}, vco_code, m_vco);
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1447));
    m_mode = 8'h00; m_vlo = 8'h00; m_alo = 8'hA0; m_vco = 12'd2048; m_agc = 12'd1440;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 3'd7, 8'hED, "R2 mode fields");
    drive(1'b1, 3'd7, 8'h00, "R2 mode clear");
    drive(1'b1, 3'd4, 8'h3C, "R3 vco low hold");
    drive(1'b1, 3'd5, 8'h81, "R3 agc low hold");
    drive(1'b1, 3'd7, 8'h10, "R2 select high");
    drive(1'b1, 3'd4, 8'hF7, "R4 R5 vco high upper ignored");
    chk("R4 vco value", vco_code, 12'h73C);
    chk("R6 agc untouched", agc_code, 12'd1440);
    drive(1'b1, 3'd5, 8'h02, "R4 agc high");
    chk("R6 agc value", agc_code, 12'h281);
    drive(1'b1, 3'd4, 8'h0A, "R9 vco reuse low");
    chk("R9 vco value", vco_code, 12'hA3C);
    for (int a = 0; a < 7; a++)
      if (a != 4 && a != 5) drive(1'b1, 3'(a), 8'hFF, "R7 other address");
    drive(1'b0, 3'd4, 8'h05, "R8 no strobe dac");
    drive(1'b0, 3'd7, 8'hAA, "R8 no strobe mode");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ra;
      ra = 3'($urandom_range(7));
      if ($urandom_range(3) == 0) ra = 3'd7;
      drive(($urandom_range(4) != 0), ra, 8'($urandom), "R6 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule